// File: doc/BRIEF.md
# Nibble and Byte Crossbar Lookup Unit

This unit performs a table lookup on every element of a register-wide word at once. The table operand is split into equal-width elements. The index operand is split into elements of the same width. Each result element takes the table element that the index in the same position selects. If that index points past the last table element, the result element is zero instead. A mode input sets the element width to 4 bits (nibbles) or 8 bits (bytes). The word width XLEN is a parameter and may be 32 or 64.

The unit sits in an execution pipeline as one stage. The lookup is purely combinational and the result is captured in an output register, so the answer appears one clock after the operands. An enable input reports whether the crossbar extension is switched on. When the design is built with the base bit-manipulation extension present and that enable is clear, the unit raises an illegal flag and forces the result to zero. Raising the trap is left to the surrounding core.

Top module: `xbar_lookup_unit`

## Requirements
- R1: With `mode_i`=0 (nibble mode), result nibble i (bits 4i+3..4i) equals the table nibble at position k, where k is index nibble i and k < XLEN/4. That table nibble is `table_i >> (4*k)`, keeping the low 4 bits.
- R2: With `mode_i`=1 (byte mode), result byte i (bits 8i+7..8i) equals the table byte at position k, where k is index byte i and k < XLEN/8. That table byte is `table_i >> (8*k)`, keeping the low 8 bits.
- R3: In nibble mode, a lane whose index is XLEN/4 or more gives 0. For XLEN=32 this covers indices 8 to 15. For XLEN=64 no nibble index is out of range.
- R4: In byte mode, a lane whose index is XLEN/8 or more gives 0. That is indices 4 to 255 for XLEN=32 and 8 to 255 for XLEN=64.
- R5: When parameter `HAS_BASE_EXT`=1 and `xperm_en_i`=0, `illegal_o` is 1 and `result_o` is all zeros. Otherwise `illegal_o` is 0.
- R6: When `HAS_BASE_EXT`=0, `xperm_en_i` has no effect: `illegal_o` stays 0 and the lookup result is produced.
- R7: Outputs are registered. `result_o` and `illegal_o` reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: A synchronous active-high `rst` clears `result_o` and `illegal_o` to 0.
- R9: Lanes are independent. Several lanes may carry the same index, and each one returns the same table element without affecting the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Element width: 0 = 4-bit, 1 = 8-bit |
| table_i | input | XLEN | Table of elements |
| index_i | input | XLEN | Vector of indices |
| xperm_en_i | input | 1 | Crossbar extension enabled |
| result_o | output | XLEN | Registered lookup result |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
The in-range lookup and the zero fill for out-of-range indices can occur in the same cycle, in neighbouring lanes of one word. The bench provokes this with index words that mix valid and out-of-range indices in both modes. It also applies a word in which every lane repeats one index. Each result word is compared in full against a lane-by-lane model that is built from R1 to R4. A second instance, built without the base extension, receives the same disabled-enable stimulus as the main instance. The bench checks the illegal gating on the main instance against the unaffected lookup on the second.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    XB_NIBBLE = 1'b0,
    XB_BYTE   = 1'b1
  } xbar_mode_e;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/xbar_elem_select.sv
// One output lane: pick the table element addressed by idx, zero when idx is out of range.
module xbar_elem_select #(
  parameter int XLEN = 32,
  parameter int EW   = 4
) (
  input  logic [EW-1:0]   idx,
  input  logic [XLEN-1:0] tbl,
  output logic [EW-1:0]   elem
);
  localparam int NELEM   = XLEN / EW;
  localparam bit HAS_OOB = (NELEM < (1 << EW));

  always_comb begin
    elem = '0;
    for (int k = 0; k < NELEM; k++) begin
      if (idx == EW'(k)) elem = tbl[k*EW +: EW];
    end
  end

  generate
    if (HAS_OOB) begin : g_oob_chk
      // Covers R3 (nibble lanes) and R4 (byte lanes)
      always_comb begin
        if (!$isunknown(idx) && ({1'b0, idx} >= (EW+1)'(NELEM))) begin
          assert_oob_zero_R4: assert (elem == '0);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xbar_vec_lookup.sv
// All lanes of one element width, in parallel (R9).
module xbar_vec_lookup #(
  parameter int XLEN = 32,
  parameter int EW   = 4
) (
  input  logic [XLEN-1:0] tbl,
  input  logic [XLEN-1:0] idx_vec,
  output logic [XLEN-1:0] res
);
  localparam int NLANE = XLEN / EW;

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      xbar_elem_select #(.XLEN(XLEN), .EW(EW)) sel_i (
        .idx  (idx_vec[g*EW +: EW]),
        .tbl  (tbl),
        .elem (res[g*EW +: EW])
      );
    end
  endgenerate
endmodule

// File: rtl/xbar_legal_gate.sv
// Illegal-instruction decision from build option and enable bit (R5, R6).
module xbar_legal_gate #(
  parameter bit HAS_BASE_EXT = 1'b1
) (
  input  logic xperm_en,
  output logic illegal
);
  generate
    if (HAS_BASE_EXT) begin : g_base
      assign illegal = ~xperm_en;
    end else begin : g_nobase
      logic unused_en;
      assign unused_en = xperm_en;
      assign illegal   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/xbar_lookup_unit.sv
module xbar_lookup_unit #(
  parameter int XLEN         = 32,
  parameter bit HAS_BASE_EXT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_i,
  input  logic [XLEN-1:0] table_i,
  input  logic [XLEN-1:0] index_i,
  input  logic            xperm_en_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  import xbar_pkg::*;

  xbar_mode_e      mode;
  logic [XLEN-1:0] nib_res;
  logic [XLEN-1:0] byte_res;
  logic [XLEN-1:0] sel_res;
  logic            illegal_d;

  initial begin
    assert_xlen_legal_R1: assert (XLEN == 32 || XLEN == 64);
  end

  assign mode = xbar_mode_e'(mode_i);

  xbar_vec_lookup #(.XLEN(XLEN), .EW(NIB_W)) nib_lu_i (
    .tbl     (table_i),
    .idx_vec (index_i),
    .res     (nib_res)
  );

  xbar_vec_lookup #(.XLEN(XLEN), .EW(BYTE_W)) byte_lu_i (
    .tbl     (table_i),
    .idx_vec (index_i),
    .res     (byte_res)
  );

  xbar_legal_gate #(.HAS_BASE_EXT(HAS_BASE_EXT)) gate_i (
    .xperm_en (xperm_en_i),
    .illegal  (illegal_d)
  );

  always_comb begin
    sel_res = (mode == XB_BYTE) ? byte_res : nib_res;
    if (illegal_d) sel_res = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= sel_res;
      illegal_o <= illegal_d;
    end
  end

  assert_illegal_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (HAS_BASE_EXT && !xperm_en_i) |=> (illegal_o && result_o == '0));

  assert_base_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (!HAS_BASE_EXT && !xperm_en_i) |=> !illegal_o);

  assert_nib_lane0_R1: assert property (@(posedge clk) disable iff (rst)
    ((xperm_en_i || !HAS_BASE_EXT) && !mode_i && index_i[3:0] == 4'd0)
      |=> result_o[3:0] == $past(table_i[3:0]));

  assert_byte_lane0_R2: assert property (@(posedge clk) disable iff (rst)
    ((xperm_en_i || !HAS_BASE_EXT) && mode_i && index_i[7:0] == 8'd1)
      |=> result_o[7:0] == $past(table_i[15:8]));

  assert_illegal_excl_R5: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> result_o == '0);
endmodule

// File: tb/xbar_lookup_unit_tb.sv
module xbar_lookup_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode_i = 1'b0;
  logic [XLEN-1:0] table_i = '0;
  logic [XLEN-1:0] index_i = '0;
  logic            xperm_en_i = 1'b1;
  logic [XLEN-1:0] result_o, result_nb;
  logic            illegal_o, illegal_nb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_lookup_unit #(.XLEN(XLEN), .HAS_BASE_EXT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .table_i(table_i), .index_i(index_i),
    .xperm_en_i(xperm_en_i), .result_o(result_o), .illegal_o(illegal_o));

  xbar_lookup_unit #(.XLEN(XLEN), .HAS_BASE_EXT(1'b0)) dut_nb_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .table_i(table_i), .index_i(index_i),
    .xperm_en_i(xperm_en_i), .result_o(result_nb), .illegal_o(illegal_nb));

  function automatic logic [XLEN-1:0] model(input logic md, input logic [XLEN-1:0] tb,
                                            input logic [XLEN-1:0] ix);
    logic [XLEN-1:0] r = '0;
    int ew = md ? 8 : 4;
    int n  = XLEN / ew;
    for (int i = 0; i < n; i++) begin
      int k = 0;
      for (int b = 0; b < ew; b++) k += int'(ix[i*ew + b]) << b;
      if (k < n) begin
        logic [XLEN-1:0] sh = tb >> (k*ew);
        for (int b = 0; b < ew; b++) r[i*ew + b] = sh[b];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic md, input logic [XLEN-1:0] tb, input logic [XLEN-1:0] ix,
                       input logic en);
    @(negedge clk);
    mode_i = md; table_i = tb; index_i = ix; xperm_en_i = en;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R8", result_o, '0);
    check("R8", {31'b0, illegal_o}, '0);
  endtask

  task automatic t_nibble;
    apply(1'b0, 32'h7654_3210, 32'h0123_4567, 1'b1);
    check("R1", result_o, 32'h0123_4567);
    apply(1'b0, 32'hFEDC_BA98, 32'h3071_6254, 1'b1);
    check("R1", result_o, model(1'b0, 32'hFEDC_BA98, 32'h3071_6254));
    check("R5", {31'b0, illegal_o}, '0);
  endtask

  task automatic t_nibble_oob;
    apply(1'b0, 32'h1234_5678, 32'h8F3A_0219, 1'b1);
    check("R3", result_o, model(1'b0, 32'h1234_5678, 32'h8F3A_0219));
    apply(1'b0, 32'hFFFF_FFFF, 32'hFEDC_BA98, 1'b1);
    check("R3", result_o, 32'h0);
  endtask

  task automatic t_byte;
    apply(1'b1, 32'hDDCC_BBAA, 32'h0001_0203, 1'b1);
    check("R2", result_o, 32'hAABB_CCDD);
    apply(1'b1, 32'h4433_2211, 32'h0202_0100, 1'b1);
    check("R2", result_o, 32'h3333_2211);
  endtask

  task automatic t_byte_oob;
    apply(1'b1, 32'hDDCC_BBAA, 32'h0304_FF01, 1'b1);
    check("R4", result_o, 32'hDD00_00BB);
    apply(1'b1, 32'h8765_4321, 32'h1080_0502, 1'b1);
    check("R4", result_o, model(1'b1, 32'h8765_4321, 32'h1080_0502));
  endtask

  task automatic t_same_index;
    apply(1'b0, 32'h9ABC_DEF0, 32'h5555_5555, 1'b1);
    check("R9", result_o, 32'hBBBB_BBBB);
    apply(1'b1, 32'h9ABC_DEF0, 32'h0303_0303, 1'b1);
    check("R9", result_o, 32'h9A9A_9A9A);
  endtask

  task automatic t_illegal;
    apply(1'b1, 32'hDDCC_BBAA, 32'h0001_0203, 1'b0);
    check("R5", {31'b0, illegal_o}, 32'h1);
    check("R5", result_o, 32'h0);
    check("R6", {31'b0, illegal_nb}, 32'h0);
    check("R6", result_nb, 32'hAABB_CCDD);
    apply(1'b0, 32'h7654_3210, 32'h0000_0007, 1'b1);
    check("R5", {31'b0, illegal_o}, 32'h0);
    check("R5", result_o, 32'h0000_0007);
  endtask

  task automatic t_latency;
    logic [XLEN-1:0] prev;
    apply(1'b0, 32'h7654_3210, 32'h0000_0011, 1'b1);
    prev = result_o;
    @(negedge clk);
    mode_i = 1'b0; table_i = 32'h7654_3210; index_i = 32'h0000_0022;
    #1;
    check("R7", result_o, prev);
    @(negedge clk);
    check("R7", result_o, 32'h0000_0022);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_nibble();
    t_nibble_oob();
    t_byte();
    t_byte_oob();
    t_same_index();
    t_illegal();
    t_latency();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule